// File: doc/BRIEF.md
# DS1 Transmit Error Injector

This block sits on the transmit side of a DS1 framer, after frame assembly and before the line driver. Each clock it takes one serial bit, a two-bit tag that says what role that bit plays in the frame, and a framing-mode select (D4 superframe or extended superframe). It emits the bit as alternate mark inversion on a positive rail and a negative rail.

Five request inputs each ask for one deliberate error: a flipped payload bit, a flipped terminal-framing bit, a flipped signal-framing bit, a flipped CRC bit, or a bipolar violation on the line. A request is armed only by a zero-to-one change of its input. It then waits for the next bit of its own kind and corrupts exactly that one. A separate level input silences the line for as long as it is held high.

All control inputs pass through a synchronizer clocked by the transmit bit clock before they are used.

Top module: `ds1_tx_err_inject`

## Requirements
- R1: After reset both line rails are low and no error is pending, so the first mark sent goes out on the positive rail.
- R2: Only a zero-to-one change of a request input arms an error. A level held at one, a level held at zero, or a one-to-zero change arms nothing.
- R3: An armed error stays pending until the next bit of its kind is sent. It corrupts that bit only and then clears itself. Bits of other kinds sent while it waits are left unchanged.
- R4: A payload request inverts one bit tagged payload (role code 0).
- R5: A terminal framing request inverts one bit tagged terminal framing (role code 1). This works in D4 mode (mode select 0) and in ESF mode (mode select 1).
- R6: A signal framing request inverts one bit tagged signal framing (role code 2) in D4 mode only. A request made while in ESF mode is dropped and does not fire after a later change to D4.
- R7: A CRC request inverts one bit tagged CRC (role code 3) in ESF mode only. A request made while in D4 mode is dropped and does not fire after a later change to ESF.
- R8: A bipolar violation request sends the next mark with the same polarity as the mark before it. The alternation state is left unchanged, so the mark after the violation has the opposite polarity to the violation.
- R9: While loss-of-signal is forced high, both rails stay low whatever the data. The alternation state is frozen, so marks resume with the polarity that would have come next.
- R10: Outside loss of signal and violations, each one bit produces a pulse of opposite polarity to the previous pulse, and each zero bit produces no pulse. The two rails are never high together.
- R11: A control change is seen through a two-stage synchronizer. A request raised just before clock edge 1 leaves bits sampled at edges 1 to 3 untouched and can first corrupt the bit sampled at edge 4. A loss-of-signal change first affects the rails driven at edge 3. Line output lags the input bit by one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_bit | input | 1 | Serial transmit data bit |
| tx_role | input | 2 | Bit role: 0 payload, 1 terminal framing, 2 signal framing, 3 CRC |
| esf_sel | input | 1 | Framing mode: 0 D4, 1 ESF |
| inj_bpv | input | 1 | Bipolar violation request (edge armed) |
| inj_crc | input | 1 | CRC bit error request (edge armed) |
| inj_ft | input | 1 | Terminal framing bit error request (edge armed) |
| inj_fs | input | 1 | Signal framing bit error request (edge armed) |
| inj_pay | input | 1 | Payload bit error request (edge armed) |
| force_los | input | 1 | Level: silence the line while high |
| line_pos | output | 1 | Positive rail pulse |
| line_neg | output | 1 | Negative rail pulse |

## Verification
The assertions assume that the frame assembler tags each bit with exactly one role and never emits a role the current mode lacks. They also assume that control inputs change slowly next to the bit clock, so each change settles through the synchronizer before the next one. The bench drives data and roles on the falling edge and changes a control only after a bit has been sampled. It then holds that control for at least four bits before it relies on the result or changes the control again. Mode changes are always followed by four idle zero bits whose role matches no pending request, so no error fires during the transition.

// File: rtl/ds1_inj_pkg.sv
package ds1_inj_pkg;

  typedef enum logic [1:0] {
    ROLE_PAY = 2'd0,
    ROLE_FT  = 2'd1,
    ROLE_FS  = 2'd2,
    ROLE_CRC = 2'd3
  } bit_role_e;

  localparam int unsigned NUM_FRM_KINDS = 4;
  localparam int unsigned KIND_PAY = 0;
  localparam int unsigned KIND_FT  = 1;
  localparam int unsigned KIND_FS  = 2;
  localparam int unsigned KIND_CRC = 3;

  // Whether an error kind is meaningful in the current framing mode.
  function automatic logic kind_allowed(input int unsigned kind, input logic esf);
    case (kind)
      KIND_FS:  return ~esf;
      KIND_CRC: return esf;
      default:  return 1'b1;
    endcase
  endfunction

  // Whether the present bit is of the kind an error targets.
  function automatic logic kind_hits(input int unsigned kind, input bit_role_e role);
    case (kind)
      KIND_PAY: return role == ROLE_PAY;
      KIND_FT:  return role == ROLE_FT;
      KIND_FS:  return role == ROLE_FS;
      KIND_CRC: return role == ROLE_CRC;
      default:  return 1'b0;
    endcase
  endfunction

  // One AMI step: returns {next_last_neg, neg, pos}.
  function automatic logic [2:0] ami_step(input logic mark, input logic viol,
                                          input logic quiet, input logic last_neg);
    logic neg_now;
    if (quiet || !mark) return {last_neg, 1'b0, 1'b0};
    neg_now = viol ? last_neg : ~last_neg;
    return {neg_now, neg_now, ~neg_now};
  endfunction

endpackage

// File: rtl/ds1_ctl_sync.sv
module ds1_ctl_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] d_sync
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= d_async;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '0;
      else        stg[s] <= stg[s-1];
    end
  end

  assign d_sync = stg[STAGES-1];
endmodule

// File: rtl/ds1_req_arm.sv
module ds1_req_arm (
  input  logic clk,
  input  logic rst_n,
  input  logic req_lvl,
  input  logic allow,
  input  logic hit,
  output logic pending,
  output logic fire
);
  logic prev;
  logic rise;

  assign rise = req_lvl & ~prev;
  assign fire = pending & hit & allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev    <= 1'b0;
      pending <= 1'b0;
    end else begin
      prev <= req_lvl;
      if (!allow) pending <= 1'b0;
      else        pending <= (pending & ~fire) | rise;
    end
  end

  // R2: no arming without a fresh zero-to-one change
  a_r2_edge_only: assert property (@(posedge clk) disable iff (!rst_n)
    (!pending && !(req_lvl && !$past(req_lvl))) |=> !pending);

  // R3: a pending error waits while no suitable bit arrives
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !hit && allow) |=> pending);

  // R3: firing consumes the request
  a_r3_single: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !(req_lvl && !$past(req_lvl))) |=> !pending);

  // R6 / R7: a kind not valid in the mode never stays pending
  a_r7_discard: assert property (@(posedge clk) disable iff (!rst_n)
    !allow |=> !pending);
endmodule

// File: rtl/ds1_ami_enc.sv
module ds1_ami_enc
  import ds1_inj_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mark,
  input  logic viol,
  input  logic quiet,
  output logic pos,
  output logic neg
);
  logic       last_neg;
  logic [2:0] step;

  assign step = ami_step(mark, viol, quiet, last_neg);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_neg <= 1'b1;
      pos      <= 1'b0;
      neg      <= 1'b0;
    end else begin
      last_neg <= step[2];
      neg      <= step[1];
      pos      <= step[0];
    end
  end

  // R10: rails are mutually exclusive
  a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pos && neg));

  // R9: a forced silence produces no pulse
  a_r9_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> (!pos && !neg));

  // R10: a mark outside silence always yields a pulse, a space never does
  a_r10_mark: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && !quiet) |=> (pos || neg));
  a_r10_space: assert property (@(posedge clk) disable iff (!rst_n)
    !mark |=> (!pos && !neg));

  // R8: a violation repeats the polarity of the previous pulse
  a_r8_same_pol: assert property (@(posedge clk) disable iff (!rst_n)
    (mark && viol && !quiet) |=> (neg == $past(last_neg)));
endmodule

// File: rtl/ds1_tx_err_inject.sv
module ds1_tx_err_inject
  import ds1_inj_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_bit,
  input  logic [1:0] tx_role,
  input  logic       esf_sel,
  input  logic       inj_bpv,
  input  logic       inj_crc,
  input  logic       inj_ft,
  input  logic       inj_fs,
  input  logic       inj_pay,
  input  logic       force_los,
  output logic       line_pos,
  output logic       line_neg
);
  localparam int unsigned CTL_W = NUM_FRM_KINDS + 3;

  logic [CTL_W-1:0]         ctl_raw;
  logic [CTL_W-1:0]         ctl_s;
  logic [NUM_FRM_KINDS-1:0] frm_req;
  logic [NUM_FRM_KINDS-1:0] frm_pend;
  logic [NUM_FRM_KINDS-1:0] frm_fire;
  logic                     esf_s;
  logic                     los_s;
  logic                     bpv_s;
  logic                     bpv_pend;
  logic                     bpv_fire;
  logic                     eff_bit;
  bit_role_e                role;

  assign role    = bit_role_e'(tx_role);
  assign ctl_raw = {force_los, esf_sel, inj_bpv, inj_crc, inj_fs, inj_ft, inj_pay};

  ds1_ctl_sync #(.WIDTH(CTL_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(ctl_raw), .d_sync(ctl_s)
  );

  assign frm_req = ctl_s[NUM_FRM_KINDS-1:0];
  assign bpv_s   = ctl_s[NUM_FRM_KINDS];
  assign esf_s   = ctl_s[NUM_FRM_KINDS+1];
  assign los_s   = ctl_s[NUM_FRM_KINDS+2];

  for (genvar k = 0; k < NUM_FRM_KINDS; k++) begin : g_frm
    ds1_req_arm u_arm (
      .clk(clk), .rst_n(rst_n), .req_lvl(frm_req[k]),
      .allow(kind_allowed(k, esf_s)), .hit(kind_hits(k, role)),
      .pending(frm_pend[k]), .fire(frm_fire[k])
    );
  end

  assign eff_bit = tx_bit ^ (|frm_fire);

  ds1_req_arm u_arm_bpv (
    .clk(clk), .rst_n(rst_n), .req_lvl(bpv_s), .allow(1'b1),
    .hit(eff_bit & ~los_s), .pending(bpv_pend), .fire(bpv_fire)
  );

  ds1_ami_enc u_enc (
    .clk(clk), .rst_n(rst_n), .mark(eff_bit), .viol(bpv_fire),
    .quiet(los_s), .pos(line_pos), .neg(line_neg)
  );

  // R3: at most one bit error is applied to any bit
  a_r3_one_flip: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(frm_fire));

  // R8: a violation is always a real pulse on the line
  a_r8_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    bpv_fire |=> (line_pos || line_neg));

  // R8: violation request clears after use unless re-armed
  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (bpv_fire && !(bpv_s && !$past(bpv_s))) |=> !bpv_pend);

  // R6: no signal framing error fires in ESF mode
  a_r6_d4_only: assert property (@(posedge clk) disable iff (!rst_n)
    esf_s |-> !frm_fire[KIND_FS]);

  // R7: no CRC error fires in D4 mode
  a_r7_esf_only: assert property (@(posedge clk) disable iff (!rst_n)
    !esf_s |-> !frm_fire[KIND_CRC]);
endmodule

// File: tb/test_ds1_tx_err_inject.sv
module test_ds1_tx_err_inject;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_bit = 1'b0;
  logic [1:0] tx_role = 2'd0;
  logic       esf_sel = 1'b0;
  logic       inj_bpv = 1'b0, inj_crc = 1'b0, inj_ft = 1'b0, inj_fs = 1'b0, inj_pay = 1'b0;
  logic       force_los = 1'b0;
  logic       line_pos, line_neg;

  int  n_vec = 0;
  int  n_bad = 0;
  logic exp_last_neg = 1'b1;
  logic exp_quiet = 1'b0;
  bit   done = 1'b0;

  localparam logic [1:0] PAY = 2'd0, FT = 2'd1, FS = 2'd2, CRC = 2'd3;

  ds1_tx_err_inject i_ds1_tx_err_inject (
    .clk(clk), .rst_n(rst_n), .tx_bit(tx_bit), .tx_role(tx_role), .esf_sel(esf_sel),
    .inj_bpv(inj_bpv), .inj_crc(inj_crc), .inj_ft(inj_ft), .inj_fs(inj_fs),
    .inj_pay(inj_pay), .force_los(force_los), .line_pos(line_pos), .line_neg(line_neg)
  );

  always #10ns clk = ~clk;

  task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
    n_vec++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: rails pos/neg got %b expected %b", tag, got, exp);
    end
  endtask

  // Send one bit; expected rails from the bench's own AMI model.
  task automatic send(input logic b, input logic [1:0] role, input logic flip,
                      input logic viol, input string tag);
    logic eff, ep, en;
    @(negedge clk);
    tx_bit = b; tx_role = role;
    @(posedge clk); #5ns;
    eff = b ^ flip; ep = 1'b0; en = 1'b0;
    if (!exp_quiet && eff) begin
      if (viol) en = exp_last_neg;
      else begin en = ~exp_last_neg; exp_last_neg = en; end
      ep = ~en;
    end
    check(tag, {line_pos, line_neg}, {ep, en});
    if (line_pos && line_neg) begin
      n_bad++;
      $display("FAIL R10: both rails high got 11 expected not 11");
    end
  endtask

  task automatic idle(input int n, input logic [1:0] role, input string tag);
    for (int i = 0; i < n; i++) send(1'b0, role, 1'b0, 1'b0, tag);
  endtask

  task automatic t_reset;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #5ns;
    check("R1 reset rails", {line_pos, line_neg}, 2'b00);
    @(negedge clk); rst_n = 1'b1;
    exp_last_neg = 1'b1;
    send(1'b1, PAY, 1'b0, 1'b0, "R1 first mark positive");
  endtask

  task automatic t_sync_payload;
    esf_sel = 1'b0; idle(4, FT, "R11 setup");
    inj_pay = 1'b1;
    send(1'b1, PAY, 1'b0, 1'b0, "R11 edge1 untouched");
    send(1'b0, PAY, 1'b0, 1'b0, "R11 edge2 untouched");
    send(1'b1, PAY, 1'b0, 1'b0, "R11 edge3 untouched");
    send(1'b1, PAY, 1'b1, 1'b0, "R4 payload flipped at edge4");
    send(1'b0, PAY, 1'b0, 1'b0, "R3 only one payload bit");
    inj_pay = 1'b0; idle(4, FT, "R4 settle");
  endtask

  task automatic t_wait_kind;
    inj_pay = 1'b1; idle(4, FT, "R3 arm");
    send(1'b1, FT, 1'b0, 1'b0, "R3 other kind untouched");
    send(1'b1, FS, 1'b0, 1'b0, "R3 other kind untouched");
    send(1'b0, PAY, 1'b1, 1'b0, "R3 payload waits then flips");
    send(1'b0, PAY, 1'b0, 1'b0, "R3 cleared after use");
    inj_pay = 1'b0; idle(4, FT, "R3 settle");
  endtask

  task automatic t_edge_only;
    inj_pay = 1'b1; idle(4, FT, "R2 arm");
    send(1'b0, PAY, 1'b1, 1'b0, "R2 rising edge flips once");
    for (int i = 0; i < 6; i++) send(i[0], PAY, 1'b0, 1'b0, "R2 steady one no effect");
    inj_pay = 1'b0; idle(4, FT, "R2 fall");
    for (int i = 0; i < 6; i++) send(~i[0], PAY, 1'b0, 1'b0, "R2 falling edge no effect");
  endtask

  task automatic t_ft;
    esf_sel = 1'b0; idle(4, PAY, "R5 d4");
    inj_ft = 1'b1; idle(4, PAY, "R5 arm");
    send(1'b1, FS, 1'b0, 1'b0, "R5 Fs bit untouched");
    send(1'b1, FT, 1'b1, 1'b0, "R5 D4 terminal bit flipped");
    send(1'b1, FT, 1'b0, 1'b0, "R5 single flip");
    inj_ft = 1'b0; esf_sel = 1'b1; idle(4, PAY, "R5 esf");
    inj_ft = 1'b1; idle(4, PAY, "R5 arm esf");
    send(1'b1, CRC, 1'b0, 1'b0, "R5 CRC bit untouched");
    send(1'b0, FT, 1'b1, 1'b0, "R5 ESF framing bit flipped");
    send(1'b0, FT, 1'b0, 1'b0, "R5 single flip esf");
    inj_ft = 1'b0; idle(4, PAY, "R5 settle");
  endtask

  task automatic t_fs;
    esf_sel = 1'b0; idle(4, PAY, "R6 d4");
    inj_fs = 1'b1; idle(4, PAY, "R6 arm");
    send(1'b1, FT, 1'b0, 1'b0, "R6 Ft bit untouched");
    send(1'b1, FS, 1'b1, 1'b0, "R6 D4 Fs bit flipped");
    inj_fs = 1'b0; esf_sel = 1'b1; idle(4, PAY, "R6 esf");
    inj_fs = 1'b1; idle(4, PAY, "R6 arm esf");
    send(1'b1, FS, 1'b0, 1'b0, "R6 ESF request ignored");
    send(1'b0, FS, 1'b0, 1'b0, "R6 ESF request ignored");
    esf_sel = 1'b0; idle(4, PAY, "R6 back to d4");
    send(1'b1, FS, 1'b0, 1'b0, "R6 dropped request stays dropped");
    send(1'b0, FS, 1'b0, 1'b0, "R6 dropped request stays dropped");
    inj_fs = 1'b0; idle(4, PAY, "R6 settle");
  endtask

  task automatic t_crc;
    esf_sel = 1'b1; idle(4, PAY, "R7 esf");
    inj_crc = 1'b1; idle(4, PAY, "R7 arm");
    send(1'b1, FT, 1'b0, 1'b0, "R7 framing bit untouched");
    send(1'b1, CRC, 1'b1, 1'b0, "R7 ESF CRC bit flipped");
    inj_crc = 1'b0; esf_sel = 1'b0; idle(4, PAY, "R7 d4");
    inj_crc = 1'b1; idle(4, PAY, "R7 arm d4");
    send(1'b1, CRC, 1'b0, 1'b0, "R7 D4 request ignored");
    esf_sel = 1'b1; idle(4, PAY, "R7 back to esf");
    send(1'b1, CRC, 1'b0, 1'b0, "R7 dropped request stays dropped");
    send(1'b0, CRC, 1'b0, 1'b0, "R7 dropped request stays dropped");
    inj_crc = 1'b0; esf_sel = 1'b0; idle(4, PAY, "R7 settle");
  endtask

  task automatic t_bpv;
    send(1'b1, PAY, 1'b0, 1'b0, "R8 lead mark");
    inj_bpv = 1'b1; idle(4, PAY, "R8 arm");
    send(1'b1, PAY, 1'b0, 1'b1, "R8 violation same polarity");
    send(1'b1, PAY, 1'b0, 1'b0, "R8 next mark opposite");
    send(1'b1, PAY, 1'b0, 1'b0, "R8 alternation resumes");
    inj_bpv = 1'b0; idle(4, PAY, "R8 settle");
  endtask

  task automatic t_los;
    send(1'b1, PAY, 1'b0, 1'b0, "R9 mark before");
    force_los = 1'b1; idle(4, PAY, "R9 enter");
    exp_quiet = 1'b1;
    for (int i = 0; i < 5; i++) send(1'b1, PAY, 1'b0, 1'b0, "R9 no pulses");
    force_los = 1'b0; idle(4, PAY, "R9 leave");
    exp_quiet = 1'b0;
    send(1'b1, PAY, 1'b0, 1'b0, "R9 polarity resumes");
    send(1'b1, PAY, 1'b0, 1'b0, "R9 polarity resumes");
  endtask

  task automatic t_ami;
    logic [15:0] pat = 16'b1011_0010_1110_0101;
    for (int i = 0; i < 16; i++) send(pat[i], PAY, 1'b0, 1'b0, "R10 alternation");
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(20ns * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_up();
  end

  initial begin
    t_reset();
    t_sync_payload();
    t_wait_kind();
    t_edge_only();
    t_ft();
    t_fs();
    t_crc();
    t_bpv();
    t_los();
    t_ami();
    finish_up();
  end
endmodule